// File: doc/BRIEF.md
# Runtime Memory Integrity Sequencer

This block watches up to four memory regions for tampering by driving an external hash engine over them. Software writes a start address and a byte length for each region, picks which regions take part in the reference pass and which take part in periodic checking, and then issues a command. The reference pass hashes every selected region once and stores the returned 256-bit digest for each one. The block then waits a programmable number of cycles between bursts and hashes the checked regions again. Each new digest is compared with the stored reference for that region.

A digest that differs from its reference, a hash request that outlasts the watchdog, or a region whose range is empty or runs past the top of the 32-bit address space all stop the sequencer in an error state. Every error flag is sticky, and only the synchronous reset clears it. Once a command has been accepted, the region address and length registers are frozen, so the monitored ranges cannot be moved after checking has begun.

Register offsets on the 8-bit word bus: status 0x00 (read), command 0x04 (write), control 0x08, throttle 0x0C, watchdog upper word 0x10, watchdog lower word 0x14. Region i has its start address at 0x20+8·i and its length at 0x24+8·i.

Top module: `integrity_sequencer`

## Requirements
- R1: After reset, status reads 0, throttle reads 0x000000FF, and the watchdog reads 0x0000FFFF at 0x10 and 0xFFFFFFFF at 0x14.
- R2: A command write with bit 1 set runs a reference pass. The pass hashes, in ascending region order, each region whose control bit 4+i is set, and stores each digest. When the pass ends, status bit 1 (pass done) is set and the state field returns to 0.
- R3: A command with bits 1 and 2 both set goes from the reference pass straight into checking (state 2). Between bursts, the hash request stays low for at least the throttle value in cycles.
- R4: In checking, a region whose control bit 8+i is set and whose new digest differs from its reference sets status bit 4+i and the violation bit 2, and the state becomes 3.
- R5: Error flags and state 3 persist until reset. Any command written in state 3 is ignored: no hash request appears and status does not change.
- R6: If the hash request stays outstanding for more cycles than the loaded watchdog value, status bit 3 is set and the state becomes 3. A reply that arrives in time raises no error.
- R7: A selected region with zero length, or whose address plus length exceeds 2^32, sets status bit 8+i and the state becomes 3, and no hash request is made for it. A range that ends exactly at 2^32 is legal.
- R8: Region address and length writes take effect before any command and are ignored after a command has been accepted.
- R9: Control bits 3:1 give N, the number of hashes per burst in checking (0 counts as 1). A throttle wait follows every N hashes.
- R10: Status bit 0 (busy) is set while a pass or checking is in progress and is clear in idle and error.
- R11: Status bits 26:25 encode the state: 0 idle, 1 reference pass, 2 checking, 3 error.
- R12: The 64-bit watchdog value is written and read back as an upper word at 0x10 and a lower word at 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| hreq | output | 1 | Hash request, held until the engine reports done |
| haddr | output | 32 | Start address of the region being hashed |
| hlen | output | 32 | Length of the region being hashed |
| hdone | input | 1 | One-cycle pulse from the hash engine when the digest is valid |
| hdigest | input | 256 | Digest returned with hdone |

## Verification
The bench goes after the hand-off from the reference pass to checking. A design that compared during the first pass, or that skipped the throttle wait, would either flag a violation on untouched memory or show request gaps shorter than the throttle. It also tests the range check exactly at the top of the address space: an off-by-one wrap test would either reject a region ending at 2^32 or hash one that runs one byte past it. The remaining corner cases are a silent hash engine that must trip the watchdog, commands written after an error, and region writes after lock. A design whose errors were not sticky, or whose lock leaked, would issue new requests or read back the new range.

// File: rtl/rtchk_pkg.sv
package rtchk_pkg;

    localparam int REGIONS = 4;
    localparam int IDXW    = $clog2(REGIONS);

    // register offsets on the byte-addressed word bus
    localparam logic [7:0] OFF_STATUS = 8'h00;
    localparam logic [7:0] OFF_CMD    = 8'h04;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_THR    = 8'h0C;
    localparam logic [7:0] OFF_WD_HI  = 8'h10;
    localparam logic [7:0] OFF_WD_LO  = 8'h14;
    localparam logic [2:0] RGN_PAGE   = 3'b001;   // 0x20..0x3F

    localparam logic [31:0] THR_RESET = 32'h0000_00FF;
    localparam logic [63:0] WD_RESET  = 64'h0000_FFFF_FFFF_FFFF;

    // state field encodings seen by software
    localparam logic [1:0] CS_IDLE = 2'd0;
    localparam logic [1:0] CS_ONCE = 2'd1;
    localparam logic [1:0] CS_RUN  = 2'd2;
    localparam logic [1:0] CS_ERR  = 2'd3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCAN,
        PH_REQ,
        PH_WAIT,
        PH_ERR
    } phase_t;

    typedef struct packed {
        logic [4:0]         rsv_hi;
        logic [1:0]         cs;
        logic [12:0]        rsv_lo;
        logic [REGIONS-1:0] bad_range;
        logic [REGIONS-1:0] mismatch;
        logic               hash_err;
        logic               violation;
        logic               pass_done;
        logic               busy;
    } status_t;

    typedef struct packed {
        logic [REGIONS-1:0] chk_en;
        logic [REGIONS-1:0] ref_en;
        logic [2:0]         burst;
    } ctrl_t;

    // empty range, or one ending beyond the top of the 32-bit space
    function automatic logic range_bad(input logic [31:0] base, input logic [31:0] len);
        logic [32:0] end_excl;
        end_excl = {1'b0, base} + {1'b0, len};
        return (len == 32'd0) || (end_excl > 33'h1_0000_0000);
    endfunction

endpackage

// File: rtl/rtchk_regs.sv
module rtchk_regs
    import rtchk_pkg::*;
#(
    parameter int AW  = 32,
    parameter int WDW = 64,
    parameter int THW = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [31:0]               wr_data,
    input  logic                      locked,
    output logic [REGIONS-1:0][AW-1:0] rg_base,
    output logic [REGIONS-1:0][AW-1:0] rg_len,
    output ctrl_t                     ctrl,
    output logic [THW-1:0]            throttle,
    output logic [WDW-1:0]            wd_load,
    output logic                      cmd_valid,
    output logic                      cmd_once,
    output logic                      cmd_run
);

    localparam int HALF = WDW / 2;

    logic rgn_hit;
    assign rgn_hit = wr_en && (wr_addr[7:5] == RGN_PAGE) && (wr_addr[1:0] == 2'b00);

    for (genvar g = 0; g < REGIONS; g++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst) begin
                rg_base[g] <= '0;
                rg_len[g]  <= '0;
            end else if (rgn_hit && !locked && (wr_addr[4:3] == IDXW'(g))) begin
                if (wr_addr[2]) rg_len[g]  <= AW'(wr_data);
                else            rg_base[g] <= AW'(wr_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            throttle <= THW'(THR_RESET);
            wd_load  <= WDW'(WD_RESET);
        end else if (wr_en) begin
            case (wr_addr)
                OFF_CTRL:  ctrl <= '{chk_en: wr_data[11:8], ref_en: wr_data[7:4], burst: wr_data[3:1]};
                OFF_THR:   throttle <= THW'(wr_data);
                OFF_WD_HI: wd_load[WDW-1:HALF] <= wr_data[HALF-1:0];
                OFF_WD_LO: wd_load[HALF-1:0]   <= wr_data[HALF-1:0];
                default: ;
            endcase
        end
    end

    assign cmd_valid = wr_en && (wr_addr == OFF_CMD);
    assign cmd_once  = wr_data[1];
    assign cmd_run   = wr_data[2];

    // R8: no region register moves once the sequencer has locked them
    a_r8_region_lock: assert property (@(posedge clk) disable iff (rst)
        (locked && rgn_hit) |=> ($stable(rg_base) && $stable(rg_len)));

endmodule

// File: rtl/rtchk_refstore.sv
module rtchk_refstore
    import rtchk_pkg::*;
#(
    parameter int DW = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDXW-1:0]    idx,
    input  logic [DW-1:0]      digest,
    input  logic               cap_en,
    output logic               differs,
    output logic [REGIONS-1:0] ref_valid
);

    logic [REGIONS-1:0][DW-1:0] ref_q;

    for (genvar g = 0; g < REGIONS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ref_q[g]     <= '0;
                ref_valid[g] <= 1'b0;
            end else if (cap_en && (idx == IDXW'(g))) begin
                ref_q[g]     <= digest;
                ref_valid[g] <= 1'b1;
            end
        end
    end

    assign differs = (ref_q[idx] != digest);

    // R2: a captured slot keeps its valid flag until reset
    a_r2_ref_kept: assert property (@(posedge clk) disable iff (rst)
        ref_valid[idx] |=> ref_valid[$past(idx)]);

endmodule

// File: rtl/rtchk_seq.sv
module rtchk_seq
    import rtchk_pkg::*;
#(
    parameter int AW  = 32,
    parameter int WDW = 64,
    parameter int THW = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic                       cmd_once,
    input  logic                       cmd_run,
    input  ctrl_t                      ctrl,
    input  logic [THW-1:0]             throttle,
    input  logic [WDW-1:0]             wd_load,
    input  logic [REGIONS-1:0][AW-1:0] rg_base,
    input  logic [REGIONS-1:0][AW-1:0] rg_len,
    input  logic                       hdone,
    input  logic                       differs,
    input  logic [REGIONS-1:0]         ref_valid,
    output logic                       hreq,
    output logic [AW-1:0]              haddr,
    output logic [AW-1:0]              hlen,
    output logic [IDXW-1:0]            idx,
    output logic                       cap_en,
    output logic                       locked,
    output status_t                    status
);

    localparam logic [IDXW-1:0] LAST = IDXW'(REGIONS - 1);

    phase_t             phase;
    logic               once_q, run_q;
    logic [WDW-1:0]     wd_q;
    logic [THW-1:0]     tcnt_q;
    logic [2:0]         bcnt_q;
    logic               hd_q, sv_q, he_q;
    logic [REGIONS-1:0] mis_q, ae_q;

    logic       elig, bad, burst_full;
    logic [2:0] beff;
    logic [1:0] cs;

    assign elig  = once_q ? ctrl.ref_en[idx] : (ctrl.chk_en[idx] && ref_valid[idx]);
    assign bad   = range_bad(rg_base[idx], rg_len[idx]);
    assign beff  = (ctrl.burst == 3'd0) ? 3'd1 : ctrl.burst;
    assign burst_full = ({1'b0, bcnt_q} + 4'd1) >= {1'b0, beff};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            idx    <= '0;
            once_q <= 1'b0;
            run_q  <= 1'b0;
            wd_q   <= '0;
            tcnt_q <= '0;
            bcnt_q <= '0;
            hd_q   <= 1'b0;
            sv_q   <= 1'b0;
            he_q   <= 1'b0;
            mis_q  <= '0;
            ae_q   <= '0;
            locked <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (cmd_valid && (cmd_once || cmd_run)) begin
                    locked <= 1'b1;
                    idx    <= '0;
                    bcnt_q <= '0;
                    once_q <= cmd_once;
                    run_q  <= cmd_run;
                    phase  <= PH_SCAN;
                end
                PH_SCAN: begin
                    if (elig) begin
                        if (bad) begin
                            ae_q[idx] <= 1'b1;
                            phase     <= PH_ERR;
                        end else begin
                            wd_q  <= wd_load;
                            phase <= PH_REQ;
                        end
                    end else if (idx != LAST) begin
                        idx <= idx + 1'b1;
                    end else begin
                        idx    <= '0;
                        bcnt_q <= '0;
                        if (once_q) begin
                            hd_q <= 1'b1;
                            if (run_q) begin
                                once_q <= 1'b0;
                                tcnt_q <= throttle;
                                phase  <= PH_WAIT;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            tcnt_q <= throttle;
                            phase  <= PH_WAIT;
                        end
                    end
                end
                PH_REQ: begin
                    if (hdone) begin
                        if (!once_q && differs) begin
                            mis_q[idx] <= 1'b1;
                            sv_q       <= 1'b1;
                            phase      <= PH_ERR;
                        end else if (!once_q && (idx == LAST || burst_full)) begin
                            idx    <= idx + 1'b1;
                            bcnt_q <= '0;
                            tcnt_q <= throttle;
                            phase  <= PH_WAIT;
                        end else if (once_q && idx == LAST) begin
                            idx    <= '0;
                            bcnt_q <= '0;
                            hd_q   <= 1'b1;
                            if (run_q) begin
                                once_q <= 1'b0;
                                tcnt_q <= throttle;
                                phase  <= PH_WAIT;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            idx    <= idx + 1'b1;
                            bcnt_q <= bcnt_q + 3'd1;
                            phase  <= PH_SCAN;
                        end
                    end else if (wd_q == '0) begin
                        he_q  <= 1'b1;
                        phase <= PH_ERR;
                    end else begin
                        wd_q <= wd_q - 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (tcnt_q == '0) phase  <= PH_SCAN;
                    else              tcnt_q <= tcnt_q - 1'b1;
                end
                default: phase <= PH_ERR;
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_IDLE: cs = CS_IDLE;
            PH_ERR:  cs = CS_ERR;
            default: cs = once_q ? CS_ONCE : CS_RUN;
        endcase
    end

    assign hreq   = (phase == PH_REQ);
    assign haddr  = rg_base[idx];
    assign hlen   = rg_len[idx];
    assign cap_en = hreq && hdone && once_q;

    always_comb begin
        status           = '0;
        status.cs        = cs;
        status.bad_range = ae_q;
        status.mismatch  = mis_q;
        status.hash_err  = he_q;
        status.violation = sv_q;
        status.pass_done = hd_q;
        status.busy      = (cs == CS_ONCE) || (cs == CS_RUN);
    end

    // R5: the error state is never left
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (status.cs == CS_ERR) |=> (status.cs == CS_ERR));

    // R4: a raised violation stays raised and implies the error state
    a_r4_violation_sticky: assert property (@(posedge clk) disable iff (rst)
        sv_q |=> (sv_q && status.cs == CS_ERR));

    // R6: an expired watchdog with no reply raises the hashing error
    a_r6_timeout_flag: assert property (@(posedge clk) disable iff (rst)
        (hreq && !hdone && wd_q == '0) |=> he_q);

    // R7: a request never goes out for a malformed range
    a_r7_no_bad_request: assert property (@(posedge clk) disable iff (rst)
        $rose(hreq) |-> !range_bad(haddr, hlen));

    // R3: during a throttle wait no request is outstanding
    a_r3_quiet_wait: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT) |=> (!hreq || $past(tcnt_q) == '0) || phase == PH_WAIT);

    // R10: a request is only outstanding while busy is reported
    a_r10_busy_req: assert property (@(posedge clk) disable iff (rst)
        hreq |-> status.busy);

endmodule

// File: rtl/integrity_sequencer.sv
module integrity_sequencer
    import rtchk_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 256,
    parameter int WDW = 64,
    parameter int THW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [7:0]    rd_addr,
    output logic [31:0]   rd_data,
    output logic          hreq,
    output logic [AW-1:0] haddr,
    output logic [AW-1:0] hlen,
    input  logic          hdone,
    input  logic [DW-1:0] hdigest
);

    localparam int HALF = WDW / 2;

    logic [REGIONS-1:0][AW-1:0] rg_base, rg_len;
    ctrl_t              ctrl;
    logic [THW-1:0]     throttle;
    logic [WDW-1:0]     wd_load;
    logic               cmd_valid, cmd_once, cmd_run, locked;
    logic [IDXW-1:0]    idx;
    logic               cap_en, differs;
    logic [REGIONS-1:0] ref_valid;
    status_t            status;

    rtchk_regs #(.AW(AW), .WDW(WDW), .THW(THW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .locked(locked), .rg_base(rg_base), .rg_len(rg_len), .ctrl(ctrl),
        .throttle(throttle), .wd_load(wd_load), .cmd_valid(cmd_valid),
        .cmd_once(cmd_once), .cmd_run(cmd_run)
    );

    rtchk_refstore #(.DW(DW)) u_ref (
        .clk(clk), .rst(rst), .idx(idx), .digest(hdigest), .cap_en(cap_en),
        .differs(differs), .ref_valid(ref_valid)
    );

    rtchk_seq #(.AW(AW), .WDW(WDW), .THW(THW)) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_once(cmd_once),
        .cmd_run(cmd_run), .ctrl(ctrl), .throttle(throttle), .wd_load(wd_load),
        .rg_base(rg_base), .rg_len(rg_len), .hdone(hdone), .differs(differs),
        .ref_valid(ref_valid), .hreq(hreq), .haddr(haddr), .hlen(hlen),
        .idx(idx), .cap_en(cap_en), .locked(locked), .status(status)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr[7:5] == RGN_PAGE && rd_addr[1:0] == 2'b00) begin
            rd_data = 32'(rd_addr[2] ? rg_len[rd_addr[4:3]] : rg_base[rd_addr[4:3]]);
        end else begin
            case (rd_addr)
                OFF_STATUS: rd_data = status;
                OFF_CTRL:   rd_data = {20'd0, ctrl.chk_en, ctrl.ref_en, ctrl.burst, 1'b0};
                OFF_THR:    rd_data = 32'(throttle);
                OFF_WD_HI:  rd_data = 32'(wd_load[WDW-1:HALF]);
                OFF_WD_LO:  rd_data = 32'(wd_load[HALF-1:0]);
                default:    rd_data = '0;
            endcase
        end
    end

endmodule

// File: tb/integrity_sequencer_test.sv
module integrity_sequencer_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [7:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         hreq;
    logic [31:0]  haddr, hlen;
    logic         hdone = 1'b0;
    logic [255:0] hdigest = '0;

    integer vectors = 0;
    integer miscompares = 0;
    bit     finished = 1'b0;

    // hash-engine model state
    integer      latency = 4;
    integer      busy_cnt = 0;
    bit          tamper_on = 1'b0;
    logic [31:0] tamper_addr = '0;
    bit          hreq_prev = 1'b0;
    integer      low_run = 0;
    bit          expect_quiet = 1'b0;
    logic [31:0] req_log[$];
    integer      gap_log[$];

    always #2 clk = ~clk;

    integrity_sequencer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hreq(hreq), .haddr(haddr),
        .hlen(hlen), .hdone(hdone), .hdigest(hdigest)
    );

    function automatic logic [255:0] model_digest(input logic [31:0] a, input logic [31:0] l, input bit t);
        logic [31:0] w;
        w = a ^ {l[15:0], l[31:16]} ^ 32'h5A5A_0000;
        return {8{w}} ^ {255'd0, t};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural hash engine, request logger and per-clock quiet check
    initial begin
        forever begin
            @(negedge clk);
            if (hreq && !hreq_prev) begin
                req_log.push_back(haddr);
                gap_log.push_back(low_run);
                low_run = 0;
            end
            if (!hreq) low_run++;
            if (expect_quiet) check("R5 request while in error", {31'd0, hreq}, 32'd0);
            hreq_prev = hreq;
            if (hdone) begin
                hdone = 1'b0;
            end else if (hreq) begin
                busy_cnt++;
                if (busy_cnt >= latency) begin
                    hdigest  = model_digest(haddr, hlen, tamper_on && haddr == tamper_addr);
                    hdone    = 1'b1;
                    busy_cnt = 0;
                end
            end else begin
                busy_cnt = 0;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tamper_on = 1'b0;
        expect_quiet = 1'b0;
        latency = 4;
        repeat (3) @(negedge clk);
        req_log.delete();
        gap_log.delete();
        low_run = 0;
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_settle(input integer max, output logic [31:0] st);
        st = '0;
        for (int i = 0; i < max; i++) begin
            rd(8'h00, st);
            if (st[0] == 1'b0) return;
        end
    endtask

    task automatic wait_reqs(input integer n);
        for (int i = 0; i < 20000 && req_log.size() < n; i++) @(negedge clk);
    endtask

    localparam logic [31:0] CS3 = 32'h0600_0000;

    initial begin
        logic [31:0] v, st;
        integer n0;

        // ---------------- reset state (R1, R12)
        do_reset();
        rd(8'h00, v); check("R1 status after reset", v, 32'h0);
        rd(8'h0C, v); check("R1 throttle default", v, 32'h0000_00FF);
        rd(8'h10, v); check("R12 watchdog upper default", v, 32'h0000_FFFF);
        rd(8'h14, v); check("R12 watchdog lower default", v, 32'hFFFF_FFFF);

        // ---------------- reference pass only (R2, R8, R10, R11, R12)
        wr(8'h10, 32'h0); wr(8'h14, 32'd100);
        rd(8'h10, v); check("R12 watchdog upper written", v, 32'h0);
        rd(8'h14, v); check("R12 watchdog lower written", v, 32'd100);
        wr(8'h20, 32'h1000_0000); wr(8'h24, 32'h400);
        wr(8'h30, 32'h3000_0000); wr(8'h34, 32'h100);
        rd(8'h20, v); check("R8 region write before command", v, 32'h1000_0000);
        wr(8'h08, 32'h0000_0050);                 // reference enable regions 0 and 2
        wr(8'h04, 32'h2);
        @(negedge clk); while (!hreq) @(negedge clk);
        rd(8'h00, v);
        check("R11 state field in reference pass", {30'd0, v[26:25]}, 32'd1);
        check("R10 busy during pass", {31'd0, v[0]}, 32'd1);
        wait_settle(200, st);
        check("R2 status after pass", st, 32'h0000_0002);
        check("R2 request count", req_log.size(), 32'd2);
        if (req_log.size() == 2) begin
            check("R2 first region hashed", req_log[0], 32'h1000_0000);
            check("R2 second region hashed", req_log[1], 32'h3000_0000);
        end
        wr(8'h20, 32'hDEAD_0000); wr(8'h24, 32'h1);
        rd(8'h20, v); check("R8 address locked", v, 32'h1000_0000);
        rd(8'h24, v); check("R8 length locked", v, 32'h400);

        // ---------------- pass then checking, burst of 1 (R3, R4, R5, R9, R10, R11)
        do_reset();
        wr(8'h20, 32'h1000_0000); wr(8'h24, 32'h400);
        wr(8'h28, 32'h2000_0000); wr(8'h2C, 32'h800);
        wr(8'h0C, 32'd20);
        wr(8'h08, 32'h0000_0332);                 // N=1, ref 0/1, check 0/1
        wr(8'h04, 32'h6);
        wait_reqs(6);
        rd(8'h00, v);
        check("R11 state field while checking", {30'd0, v[26:25]}, 32'd2);
        check("R10 busy while checking", {31'd0, v[0]}, 32'd1);
        check("R3 no false violation", {29'd0, v[3:2], 1'b0}, 32'd0);
        if (req_log.size() >= 6) begin
            check("R3 alternating region order", req_log[3], 32'h2000_0000);
            for (int k = 2; k < 6; k++)
                check("R3 throttle gap honoured", {31'd0, gap_log[k] >= 20}, 32'd1);
        end
        tamper_addr = 32'h2000_0000;
        tamper_on = 1'b1;
        wait_settle(400, st);
        check("R4 violation status", st, 32'h0000_0026 | CS3);
        expect_quiet = 1'b1;
        n0 = req_log.size();
        wr(8'h04, 32'h6);
        repeat (40) @(negedge clk);
        check("R5 command ignored in error", req_log.size(), n0);
        rd(8'h00, v); check("R5 status sticky", v, 32'h0000_0026 | CS3);
        expect_quiet = 1'b0;

        // ---------------- burst of 2 (R9)
        do_reset();
        wr(8'h20, 32'h1000_0000); wr(8'h24, 32'h400);
        wr(8'h28, 32'h2000_0000); wr(8'h2C, 32'h800);
        wr(8'h0C, 32'd30);
        wr(8'h08, 32'h0000_0334);                 // N=2
        wr(8'h04, 32'h6);
        wait_reqs(6);
        if (gap_log.size() >= 6) begin
            check("R9 wait before burst", {31'd0, gap_log[2] >= 30}, 32'd1);
            check("R9 no wait inside burst", {31'd0, gap_log[3] < 30}, 32'd1);
            check("R9 wait after burst", {31'd0, gap_log[4] >= 30}, 32'd1);
        end else begin
            check("R9 request count", gap_log.size(), 32'd6);
        end

        // ---------------- watchdog (R6)
        do_reset();
        latency = 100000;
        wr(8'h10, 32'h0); wr(8'h14, 32'd10);
        wr(8'h20, 32'h1000_0000); wr(8'h24, 32'h400);
        wr(8'h08, 32'h0000_0010);
        wr(8'h04, 32'h2);
        wait_settle(100, st);
        check("R6 timeout status", st, 32'h0000_0008 | CS3);

        // ---------------- range at the top of the space is legal (R7)
        do_reset();
        wr(8'h28, 32'hFFFF_FFF0); wr(8'h2C, 32'h10);
        wr(8'h08, 32'h0000_0020);
        wr(8'h04, 32'h2);
        wait_settle(200, st);
        check("R7 range ending at 2^32 legal", st, 32'h0000_0002);

        // ---------------- range one byte past the top (R7)
        do_reset();
        wr(8'h28, 32'hFFFF_FFF0); wr(8'h2C, 32'h11);
        wr(8'h08, 32'h0000_0020);
        wr(8'h04, 32'h2);
        wait_settle(50, st);
        check("R7 wrapping range flagged", st, 32'h0000_0200 | CS3);
        check("R7 no request for wrapping range", req_log.size(), 32'd0);

        // ---------------- zero length (R7)
        do_reset();
        wr(8'h20, 32'h1000_0000);
        wr(8'h08, 32'h0000_0010);
        wr(8'h04, 32'h2);
        wait_settle(50, st);
        check("R7 zero length flagged", st, 32'h0000_0100 | CS3);
        check("R7 no request for zero length", req_log.size(), 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule